// File: doc/BRIEF.md
# Receive Packet Framing Tracker

This block sits behind a receiver's preamble detector and byte assembler. After a preamble is found, it can check up to two address bytes (a network address first, then a node address), each enabled on its own. It then follows the packet body and decides where the packet ends. The length comes from one of two sources, chosen by a mode input. In fixed mode it is a configured length. In variable mode it is a size byte that sits at a programmable offset inside the packet header. Every body byte, including the two trailing CRC bytes, is passed to a receive FIFO.

The FIFO side is a valid/ready write port. `fifo_wvalid` follows `byte_valid` in the same cycle, and a byte is stored when `fifo_wvalid && fifo_wready`. The tracker cannot stall the incoming stream, so it applies no back-pressure. A byte offered while `fifo_wready` is low is lost. That loss is reported by a one-cycle overflow pulse, and the byte still counts toward the packet length.

The host can end reception at any time with `abort`. An abort returns the tracker to idle without an end-of-packet pulse. All configuration inputs must be held stable while a packet is in progress.

Top module: `rx_frame_tracker`

## Requirements
- R1: While reset is held and after it is released, `pkt_start`, `pkt_end`, `ovf_pulse` and `fifo_wvalid` are low until stimulus arrives.
- R2: In fixed mode (`cfg_fixed`=1), exactly `cfg_len`+2 body bytes are written to the FIFO. `pkt_end` pulses for one cycle after the clock edge that takes the last CRC byte. Later bytes are not written until a new preamble.
- R3: In fixed mode, a `cfg_len` value of 0 or 1 is treated as 2.
- R4: In variable mode (`cfg_fixed`=0), the body byte at index `cfg_size_ofs` (0 to 3, counted from the first body byte after the address bytes) carries the size. The bytes before it count toward the size, and the packet holds size+2 bytes.
- R5: In variable mode, a size value below `cfg_size_ofs`+1 is treated as `cfg_size_ofs`+1.
- R6: `pkt_start` pulses one cycle after the edge that samples `pre_found` when no filter is enabled. Otherwise it pulses one cycle after the edge that takes the last matching address byte. The network byte comes before the node byte, and address bytes are never written to the FIFO.
- R7: If an enabled address byte does not match, the tracker returns to idle with no `pkt_start` and no FIFO writes.
- R8: `abort` returns the tracker to idle at the next edge. It produces no `pkt_end`, and no further bytes are written.
- R9: A body byte arriving with `fifo_wready` low is dropped and raises `ovf_pulse` for one cycle after that edge. The byte still counts toward the length.
- R10: `pre_found` is ignored while an address or body byte is expected.
- R11: `fifo_wdata` equals `byte_data` for every written body byte, with `fifo_wvalid` high in the cycle the byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fixed | input | 1 | 1 selects fixed length, 0 selects in-header size byte |
| cfg_len | input | 8 | Fixed packet length in bytes |
| cfg_size_ofs | input | 2 | Index of the size byte in variable mode |
| cfg_net_en | input | 1 | Enable network address check |
| cfg_net_id | input | 8 | Expected network address |
| cfg_node_en | input | 1 | Enable node address check |
| cfg_node_id | input | 8 | Expected node address |
| pre_found | input | 1 | Preamble detected strobe |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| abort | input | 1 | Host ends reception |
| fifo_wvalid | output | 1 | FIFO write request |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_wready | input | 1 | FIFO can accept (not full) |
| pkt_start | output | 1 | Packet start pulse |
| pkt_end | output | 1 | Packet end pulse |
| ovf_pulse | output | 1 | Dropped-byte pulse |

## Verification
The hardest case to reach from the ports is a variable-mode packet whose size byte is smaller than its own position plus one. Here the length must be raised to the header boundary, not ended before the size is known. The stimulus places a size of 1 at offset 2 and sends extra bytes after the expected end, so an early or late end shows in the write count. A dropped byte during back-pressure is also reached deliberately: `fifo_wready` is lowered for exactly one body byte, and the bench checks that the end pulse still lands on the original count.

// File: rtl/rft_pkg.sv
package rft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NET  = 2'd1,
    ST_NODE = 2'd2,
    ST_BODY = 2'd3
  } rft_state_e;
endpackage

// File: rtl/rft_addr_match.sv
module rft_addr_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] net_id,
  input  logic [DW-1:0] node_id,
  output logic          net_hit,
  output logic          node_hit
);
  assign net_hit  = (rx_byte == net_id);
  assign node_hit = (rx_byte == node_id);
endmodule

// File: rtl/rft_len_unit.sv
module rft_len_unit #(
  parameter int DW        = 8,
  parameter int OFS_W     = 2,
  parameter int CRC_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             fixed_mode,
  input  logic [DW-1:0]    fixed_len,
  input  logic [OFS_W-1:0] size_ofs,
  input  logic [DW-1:0]    rx_byte,
  output logic             last
);
  localparam int CW = DW + 2;

  logic [CW-1:0] cnt;
  logic [DW-1:0] size_q;
  logic          size_ok;
  logic [DW-1:0] fixed_eff;
  logic [DW-1:0] size_min;
  logic [DW-1:0] size_eff;
  logic [DW-1:0] len_eff;
  logic          have_len;
  logic [CW-1:0] last_idx;

  assign fixed_eff = (fixed_len < DW'(2)) ? DW'(2) : fixed_len;
  assign size_min  = DW'(size_ofs) + DW'(1);
  assign size_eff  = (size_q < size_min) ? size_min : size_q;
  assign len_eff   = fixed_mode ? fixed_eff : size_eff;
  assign have_len  = fixed_mode | size_ok;
  assign last_idx  = CW'(len_eff) + CW'(CRC_BYTES - 1);
  assign last      = take && have_len && (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      size_q  <= '0;
      size_ok <= 1'b0;
    end else if (clear) begin
      cnt     <= '0;
      size_ok <= 1'b0;
    end else if (take) begin
      cnt <= cnt + CW'(1);
      if (!fixed_mode && cnt == CW'(size_ofs)) begin
        size_q  <= rx_byte;
        size_ok <= 1'b1;
      end
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_len && !clear) |-> (cnt <= last_idx));

  // R4
  size_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear && !fixed_mode && cnt > CW'(size_ofs)) |-> size_ok);
endmodule

// File: rtl/rx_frame_tracker.sv
module rx_frame_tracker #(
  parameter int DW        = 8,
  parameter int OFS_W     = 2,
  parameter int CRC_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fixed,
  input  logic [DW-1:0]    cfg_len,
  input  logic [OFS_W-1:0] cfg_size_ofs,
  input  logic             cfg_net_en,
  input  logic [DW-1:0]    cfg_net_id,
  input  logic             cfg_node_en,
  input  logic [DW-1:0]    cfg_node_id,
  input  logic             pre_found,
  input  logic             byte_valid,
  input  logic [DW-1:0]    byte_data,
  input  logic             abort,
  output logic             fifo_wvalid,
  output logic [DW-1:0]    fifo_wdata,
  input  logic             fifo_wready,
  output logic             pkt_start,
  output logic             pkt_end,
  output logic             ovf_pulse
);
  import rft_pkg::*;

  rft_state_e st;
  logic       net_hit;
  logic       node_hit;
  logic       body_take;
  logic       last_byte;

  rft_addr_match #(.DW(DW)) u_match (
    .rx_byte  (byte_data),
    .net_id   (cfg_net_id),
    .node_id  (cfg_node_id),
    .net_hit  (net_hit),
    .node_hit (node_hit)
  );

  assign body_take   = (st == ST_BODY) && byte_valid && !abort;
  assign fifo_wvalid = body_take;
  assign fifo_wdata  = byte_data;

  rft_len_unit #(.DW(DW), .OFS_W(OFS_W), .CRC_BYTES(CRC_BYTES)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (st != ST_BODY),
    .take       (body_take),
    .fixed_mode (cfg_fixed),
    .fixed_len  (cfg_len),
    .size_ofs   (cfg_size_ofs),
    .rx_byte    (byte_data),
    .last       (last_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pkt_start <= 1'b0;
      pkt_end   <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      pkt_start <= 1'b0;
      pkt_end   <= 1'b0;
      ovf_pulse <= 1'b0;
      if (abort) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (pre_found) begin
            if (cfg_net_en)       st <= ST_NET;
            else if (cfg_node_en) st <= ST_NODE;
            else begin
              st        <= ST_BODY;
              pkt_start <= 1'b1;
            end
          end
          ST_NET: if (byte_valid) begin
            if (!net_hit)         st <= ST_IDLE;
            else if (cfg_node_en) st <= ST_NODE;
            else begin
              st        <= ST_BODY;
              pkt_start <= 1'b1;
            end
          end
          ST_NODE: if (byte_valid) begin
            if (!node_hit) st <= ST_IDLE;
            else begin
              st        <= ST_BODY;
              pkt_start <= 1'b1;
            end
          end
          ST_BODY: if (byte_valid) begin
            ovf_pulse <= !fifo_wready;
            if (last_byte) begin
              pkt_end <= 1'b1;
              st      <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(byte_valid && !fifo_wready && !abort));

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st == ST_IDLE && !pkt_end && !pkt_start));

  // R6
  start_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (st == ST_BODY && !pkt_end));

  // R2
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> ($past(st == ST_BODY && byte_valid) && st == ST_IDLE));
endmodule

// File: tb/sim_rx_frame_tracker.sv
module sim_rx_frame_tracker;
  typedef struct packed {
    logic       fixed;
    logic [7:0] flen;
    logic [1:0] ofs;
    logic       neten;
    logic       nodeen;
    logic [7:0] netb;
    logic [7:0] nodeb;
    logic [7:0] sizev;
    logic [9:0] nsend;
    logic       exp_start;
    logic [9:0] exp_wr;
    logic       exp_end;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd4,   2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd0,  10'd9,   1'b1, 10'd6,   1'b1}, // R2
    '{1'b1, 8'd0,   2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd0,  10'd7,   1'b1, 10'd4,   1'b1}, // R3
    '{1'b1, 8'd255, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd0,  10'd260, 1'b1, 10'd257, 1'b1}, // R2
    '{1'b0, 8'd9,   2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd5,  10'd10,  1'b1, 10'd7,   1'b1}, // R4
    '{1'b0, 8'd9,   2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 8'd10, 10'd15,  1'b1, 10'd12,  1'b1}, // R4
    '{1'b0, 8'd9,   2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'd1,  10'd8,   1'b1, 10'd5,   1'b1}, // R5
    '{1'b1, 8'd3,   2'd0, 1'b1, 1'b1, 8'h5A, 8'h3C, 8'd0,  10'd8,   1'b1, 10'd5,   1'b1}, // R6
    '{1'b1, 8'd3,   2'd0, 1'b1, 1'b0, 8'h5B, 8'h00, 8'd0,  10'd8,   1'b0, 10'd0,   1'b0}, // R7
    '{1'b1, 8'd3,   2'd0, 1'b0, 1'b1, 8'h00, 8'h3D, 8'd0,  10'd8,   1'b0, 10'd0,   1'b0}, // R7
    '{1'b1, 8'd3,   2'd0, 1'b1, 1'b1, 8'h5A, 8'h00, 8'd0,  10'd8,   1'b0, 10'd0,   1'b0}  // R7
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fixed = 1'b1;
  logic [7:0] cfg_len = 8'd4;
  logic [1:0] cfg_size_ofs = 2'd0;
  logic       cfg_net_en = 1'b0;
  logic [7:0] cfg_net_id = 8'h5A;
  logic       cfg_node_en = 1'b0;
  logic [7:0] cfg_node_id = 8'h3C;
  logic       pre_found = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       abort = 1'b0;
  logic       fifo_wready = 1'b1;
  logic       fifo_wvalid;
  logic [7:0] fifo_wdata;
  logic       pkt_start;
  logic       pkt_end;
  logic       ovf_pulse;

  int checks = 0;
  int errors = 0;
  int n_wr = 0, n_st = 0, n_end = 0, n_ovf = 0;
  logic [7:0] last_wd = 8'h00;
  logic data_bad = 1'b0;

  always #10 clk = ~clk;

  rx_frame_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fixed(cfg_fixed), .cfg_len(cfg_len),
    .cfg_size_ofs(cfg_size_ofs), .cfg_net_en(cfg_net_en), .cfg_net_id(cfg_net_id),
    .cfg_node_en(cfg_node_en), .cfg_node_id(cfg_node_id), .pre_found(pre_found),
    .byte_valid(byte_valid), .byte_data(byte_data), .abort(abort),
    .fifo_wvalid(fifo_wvalid), .fifo_wdata(fifo_wdata), .fifo_wready(fifo_wready),
    .pkt_start(pkt_start), .pkt_end(pkt_end), .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) begin
    if (fifo_wvalid && fifo_wready) begin
      n_wr    <= n_wr + 1;
      last_wd <= fifo_wdata;
      if (fifo_wdata != byte_data) data_bad <= 1'b1; // R11
    end
    if (pkt_start) n_st  <= n_st + 1;
    if (pkt_end)   n_end <= n_end + 1;
    if (ovf_pulse) n_ovf <= n_ovf + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input bit bv, input logic [7:0] d, input bit pf, input bit ab);
    byte_valid = bv; byte_data = d; pre_found = pf; abort = ab;
    @(posedge clk); #2;
    byte_valid = 1'b0; pre_found = 1'b0; abort = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int b_wr, b_st, b_end, b_ovf;
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #2;
    // R1
    chk(!pkt_start && !pkt_end && !ovf_pulse && !fifo_wvalid, "R1 in reset", 1, 0);
    rst_n = 1'b1;
    idle(2);
    chk(!pkt_start && !pkt_end && !ovf_pulse && !fifo_wvalid, "R1 after reset", 1, 0);

    for (int v = 0; v < NV; v++) begin
      cfg_fixed = VECS[v].fixed; cfg_len = VECS[v].flen; cfg_size_ofs = VECS[v].ofs;
      cfg_net_en = VECS[v].neten; cfg_node_en = VECS[v].nodeen;
      b_wr = n_wr; b_st = n_st; b_end = n_end;
      put(1'b0, 8'h00, 1'b1, 1'b0);
      if (VECS[v].neten)  put(1'b1, VECS[v].netb, 1'b0, 1'b0);
      if (VECS[v].nodeen) put(1'b1, VECS[v].nodeb, 1'b0, 1'b0);
      for (int i = 0; i < int'(VECS[v].nsend); i++) begin
        d = (!VECS[v].fixed && i == int'(VECS[v].ofs)) ? VECS[v].sizev : 8'(8'h80 + i);
        put(1'b1, d, 1'b0, 1'b0);
      end
      idle(3);
      chk(n_st - b_st == int'(VECS[v].exp_start), $sformatf("R6/R7 start vec%0d", v), n_st - b_st, VECS[v].exp_start);
      chk(n_wr - b_wr == int'(VECS[v].exp_wr), $sformatf("R2/R3/R4/R5 writes vec%0d", v), n_wr - b_wr, VECS[v].exp_wr);
      chk(n_end - b_end == int'(VECS[v].exp_end), $sformatf("R2 end vec%0d", v), n_end - b_end, VECS[v].exp_end);
      if (VECS[v].exp_wr != 0)
        chk(last_wd == 8'(8'h80 + VECS[v].exp_wr - 1), $sformatf("R11 last data vec%0d", v), last_wd, 8'(8'h80 + VECS[v].exp_wr - 1));
    end
    chk(!data_bad, "R11 data path", data_bad, 0);

    // R6: start pulse timing with no filters
    cfg_fixed = 1'b1; cfg_len = 8'd4; cfg_net_en = 1'b0; cfg_node_en = 1'b0;
    put(1'b0, 8'h00, 1'b1, 1'b0);
    chk(pkt_start, "R6 start timing", pkt_start, 1);
    idle(1);
    chk(!pkt_start, "R6 start one cycle", pkt_start, 0);
    // R8: abort mid-packet
    b_wr = n_wr; b_end = n_end;
    for (int i = 0; i < 3; i++) put(1'b1, 8'h10, 1'b0, 1'b0);
    put(1'b0, 8'h00, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) put(1'b1, 8'h11, 1'b0, 1'b0);
    idle(2);
    chk(n_wr - b_wr == 3, "R8 writes after abort", n_wr - b_wr, 3);
    chk(n_end == b_end, "R8 no end", n_end - b_end, 0);

    // R9: one byte dropped while FIFO full
    b_wr = n_wr; b_end = n_end; b_ovf = n_ovf;
    put(1'b0, 8'h00, 1'b1, 1'b0);
    put(1'b1, 8'h20, 1'b0, 1'b0);
    fifo_wready = 1'b0;
    put(1'b1, 8'h21, 1'b0, 1'b0);
    fifo_wready = 1'b1;
    chk(ovf_pulse, "R9 ovf timing", ovf_pulse, 1);
    for (int i = 0; i < 7; i++) put(1'b1, 8'h22, 1'b0, 1'b0);
    idle(2);
    chk(n_ovf - b_ovf == 1, "R9 ovf count", n_ovf - b_ovf, 1);
    chk(n_wr - b_wr == 5, "R9 writes", n_wr - b_wr, 5);
    chk(n_end - b_end == 1, "R9 end on count", n_end - b_end, 1);

    // R10: preamble during body is ignored
    b_wr = n_wr; b_st = n_st; b_end = n_end;
    put(1'b0, 8'h00, 1'b1, 1'b0);
    put(1'b1, 8'h30, 1'b0, 1'b0);
    put(1'b1, 8'h31, 1'b0, 1'b0);
    put(1'b0, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 7; i++) put(1'b1, 8'h32, 1'b0, 1'b0);
    idle(2);
    chk(n_st - b_st == 1, "R10 starts", n_st - b_st, 1);
    chk(n_wr - b_wr == 6, "R10 writes", n_wr - b_wr, 6);
    chk(n_end - b_end == 1, "R10 ends", n_end - b_end, 1);
    summary();
  end
endmodule